// File: doc/BRIEF.md
# Shared Peripheral Bus Phase Sequencer

This block tracks and steers the phase of a parallel peripheral bus that up to eight devices share. It decides who owns the bus when the bus is idle. It then walks the connection through selection (or reselection), the identify message, the command bytes, data, the pointer-management messages, status and the final completion message. A target may drop off the bus in the middle of a command and come back later. The sequencer remembers that one suspended connection, so that the returning target is recognised and reselects instead of starting a fresh selection.

Byte movement is reduced to a handshake: one byte counts when `hs_valid` and `hs_ready` are both high on a clock edge. The target names the phase it wants next on `phase_req`. That request is only looked at on the handshake that completes the current phase. A request that the protocol does not allow at that point drops the bus back to idle and raises a sticky error flag.

Top module: `busphase_seq`

## Requirements
- R1: After reset `phase` is idle and `arb_grant`, `err_flag` and `disc_pend` are zero. Phase codes: IDLE=0, ARB=1, SEL=2, RESEL=3, IDENT=4, CMD=5, DATA=6, SAVE=7, RESTORE=8, DISC=9, STATUS=10, DONE=11.
- R2: In IDLE, any set bit of `arb_req` moves the phase to ARB on the next edge. During ARB, `arb_grant` is one-hot at the highest-numbered requester, whose device ID is its bit index.
- R3: `arb_req` has no effect outside IDLE: the phase holds and `arb_grant` stays zero. A device that lost arbitration is not queued, so with no request the bus stays idle.
- R4: After ARB, the winner reselects (RESEL, `reconn`=1, `init_id` restored from the suspended connection, `tgt_id`=winner) when a suspended connection exists and the winner is its target. Otherwise the winner selects (SEL, `reconn`=0, `init_id`=winner, `tgt_id`=`sel_tgt` sampled with the request).
- R5: Each transfer phase lasts until its byte count has been handshaken: CMD takes CMD_BYTES, DATA takes DATA_BYTES, and every other transfer phase takes one. Cycles without `hs_valid`&`hs_ready` leave the phase unchanged.
- R6: SEL and RESEL may only be followed by IDENT. After IDENT, a new connection must go to CMD and a reselected one must go to RESTORE.
- R7: After CMD the allowed next phases are DATA, DISC and STATUS. After RESTORE they are DATA and STATUS. After DATA they are SAVE and STATUS. After SAVE the only allowed next phase is DISC.
- R8: Completing DISC returns the bus to IDLE and records the suspended connection (`disc_pend`=1).
- R9: STATUS may only be followed by DONE. Completing DONE returns the bus to IDLE and, for a reselected connection, clears `disc_pend`.
- R10: A disallowed `phase_req` on a completing handshake returns the bus to IDLE and sets `err_flag`. The flag stays set until the next ARB cycle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_req | input | NUM_DEV | Bus request, one bit per device ID |
| sel_tgt | input | ID_W | Target the requesting initiator wants |
| hs_valid | input | 1 | Byte offered |
| hs_ready | input | 1 | Byte accepted |
| phase_req | input | 4 | Phase the target asks for next |
| phase | output | 4 | Current bus phase |
| arb_grant | output | NUM_DEV | One-hot winner during ARB |
| init_id | output | ID_W | Initiator of the current connection |
| tgt_id | output | ID_W | Target of the current connection |
| reconn | output | 1 | Current connection was reselected |
| disc_pend | output | 1 | A suspended connection is waiting |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The bench builds the sequencer with eight devices, CMD_BYTES=3 and DATA_BYTES=4. Short multi-byte phases still exercise the count boundary, and many full commands with random stalls fit in a short run. Eight devices let random request vectors cover every winner position, with lower IDs losing against higher ones. The small counts also bring several disconnect/reselect round trips and the illegal-phase paths within a few hundred cycles.

// File: rtl/busphase_pkg.sv
// Shared phase encoding for the bus phase sequencer.
package busphase_pkg;
    typedef enum logic [3:0] {
        PH_IDLE    = 4'd0,
        PH_ARB     = 4'd1,
        PH_SEL     = 4'd2,
        PH_RESEL   = 4'd3,
        PH_IDENT   = 4'd4,
        PH_CMD     = 4'd5,
        PH_DATA    = 4'd6,
        PH_SAVE    = 4'd7,
        PH_RESTORE = 4'd8,
        PH_DISC    = 4'd9,
        PH_STATUS  = 4'd10,
        PH_DONE    = 4'd11
    } phase_e;
endpackage

// File: rtl/busphase_arb.sv
// Fixed-priority arbiter: the highest set request index wins.
// Assumes: purely combinational, evaluated only while the bus is idle.
module busphase_arb #(
    parameter int NUM_DEV = 8,
    parameter int ID_W    = $clog2(NUM_DEV)
) (
    input  logic [NUM_DEV-1:0] req,
    output logic               any_req,
    output logic [ID_W-1:0]    win_id
);
    // Scan upward so the last (highest) set bit is kept.
    always_comb begin
        any_req = 1'b0;
        win_id  = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (req[i]) begin
                any_req = 1'b1;
                win_id  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/busphase_count.sv
// Byte handshake counter for one phase; flags the handshake that completes it.
// Assumes: need >= 1; clear is raised on the cycle the phase changes.
module busphase_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fire,
    input  logic [CNT_W-1:0] need,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // The final byte is the one handshaken when the count reaches need-1.
    assign last = fire && (cnt_q == CNT_W'(need - 1'b1));

    // Count handshakes, restarting at each phase boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || last) cnt_q <= '0;
        else if (fire)               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/busphase_rules.sv
// Legality table: decides whether a requested phase may follow the current one.
// Assumes: consulted only on the handshake that completes the current phase.
module busphase_rules
    import busphase_pkg::*;
(
    input  phase_e cur,
    input  logic   reconn,
    input  phase_e req,
    output logic   legal
);
    // Allowed successors per phase; DISC and DONE always release the bus.
    always_comb begin
        unique case (cur)
            PH_SEL, PH_RESEL: legal = (req == PH_IDENT);
            PH_IDENT:         legal = reconn ? (req == PH_RESTORE) : (req == PH_CMD);
            PH_CMD:           legal = (req == PH_DATA) || (req == PH_DISC) || (req == PH_STATUS);
            PH_RESTORE:       legal = (req == PH_DATA) || (req == PH_STATUS);
            PH_DATA:          legal = (req == PH_SAVE) || (req == PH_STATUS);
            PH_SAVE:          legal = (req == PH_DISC);
            PH_STATUS:        legal = (req == PH_DONE);
            PH_DISC, PH_DONE: legal = 1'b1;
            default:          legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/busphase_seq.sv
// Bus phase sequencer: arbitration, (re)selection, and the phase walk of one
// connection with a single remembered suspended connection.
// Assumes: one byte per cycle when hs_valid & hs_ready; phase_req is judged
// only on the completing handshake of a phase.
module busphase_seq
    import busphase_pkg::*;
#(
    parameter int NUM_DEV    = 8,
    parameter int ID_W       = $clog2(NUM_DEV),
    parameter int CMD_BYTES  = 6,
    parameter int DATA_BYTES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] arb_req,
    input  logic [ID_W-1:0]    sel_tgt,
    input  logic               hs_valid,
    input  logic               hs_ready,
    input  logic [3:0]         phase_req,
    output logic [3:0]         phase,
    output logic [NUM_DEV-1:0] arb_grant,
    output logic [ID_W-1:0]    init_id,
    output logic [ID_W-1:0]    tgt_id,
    output logic               reconn,
    output logic               disc_pend,
    output logic               err_flag
);
    localparam int MAX_BYTES = (CMD_BYTES > DATA_BYTES) ? CMD_BYTES : DATA_BYTES;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    phase_e            phase_q;
    logic [ID_W-1:0]   win_q, tgt_cap_q, init_q, tgt_q, dinit_q, dtgt_q;
    logic              reconn_q, err_q, dpend_q;
    logic              any_req, legal, last, fire, xfer_ph;
    logic [ID_W-1:0]   win_id;
    logic [CNT_W-1:0]  need;
    phase_e            req_ph;

    assign req_ph  = phase_e'(phase_req);
    assign xfer_ph = (phase_q != PH_IDLE) && (phase_q != PH_ARB);
    assign fire    = xfer_ph && hs_valid && hs_ready;

    busphase_arb #(.NUM_DEV(NUM_DEV), .ID_W(ID_W)) u_arb (
        .req(arb_req), .any_req(any_req), .win_id(win_id));

    busphase_rules u_rules (
        .cur(phase_q), .reconn(reconn_q), .req(req_ph), .legal(legal));

    // Byte count expected in the current phase.
    always_comb begin
        case (phase_q)
            PH_CMD:  need = CNT_W'(CMD_BYTES);
            PH_DATA: need = CNT_W'(DATA_BYTES);
            default: need = CNT_W'(1);
        endcase
    end

    logic ph_change;
    assign ph_change = !xfer_ph;

    busphase_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(ph_change), .fire(fire),
        .need(need), .last(last));

    // Phase state machine and connection bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            win_q     <= '0;
            tgt_cap_q <= '0;
            init_q    <= '0;
            tgt_q     <= '0;
            dinit_q   <= '0;
            dtgt_q    <= '0;
            reconn_q  <= 1'b0;
            err_q     <= 1'b0;
            dpend_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (any_req) begin
                    phase_q   <= PH_ARB;
                    win_q     <= win_id;
                    tgt_cap_q <= sel_tgt;
                end
                PH_ARB: begin
                    err_q <= 1'b0;
                    if (dpend_q && (win_q == dtgt_q)) begin
                        phase_q  <= PH_RESEL;
                        init_q   <= dinit_q;
                        tgt_q    <= win_q;
                        reconn_q <= 1'b1;
                    end else begin
                        phase_q  <= PH_SEL;
                        init_q   <= win_q;
                        tgt_q    <= tgt_cap_q;
                        reconn_q <= 1'b0;
                    end
                end
                PH_DISC: if (last) begin
                    phase_q <= PH_IDLE;
                    dpend_q <= 1'b1;
                    dinit_q <= init_q;
                    dtgt_q  <= tgt_q;
                end
                PH_DONE: if (last) begin
                    phase_q <= PH_IDLE;
                    if (reconn_q) dpend_q <= 1'b0;
                end
                default: if (last) begin
                    if (legal) phase_q <= req_ph;
                    else begin
                        phase_q <= PH_IDLE;
                        err_q   <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Output drive.
    always_comb begin
        arb_grant = '0;
        if (phase_q == PH_ARB) arb_grant[win_q] = 1'b1;
    end
    assign phase     = phase_q;
    assign init_id   = init_q;
    assign tgt_id    = tgt_q;
    assign reconn    = reconn_q;
    assign disc_pend = dpend_q;
    assign err_flag  = err_q;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant));
    // R2
    idle_to_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && |arb_req) |=> (phase_q == PH_ARB));
    // R3
    busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && phase_q != PH_ARB) |=> (phase_q != PH_ARB));
    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ph && !(hs_valid && hs_ready)) |=> $stable(phase_q));
    // R8
    disc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DISC && last) |=> (phase_q == PH_IDLE && dpend_q));
    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (phase_q == PH_IDLE));
endmodule

// File: tb/busphase_seq_tb_top.sv
module busphase_seq_tb_top;
    localparam int ND = 8;
    localparam int IW = 3;
    localparam int CB = 3;
    localparam int DB = 4;

    localparam logic [3:0] IDLE = 0, ARB = 1, SEL = 2, RESEL = 3, IDENT = 4,
        CMD = 5, DATA = 6, SAVE = 7, RESTORE = 8, DISC = 9, STATUS = 10, DONE = 11;

    logic clk = 0, rst_n = 0;
    logic [ND-1:0] arb_req = '0;
    logic [IW-1:0] sel_tgt = '0;
    logic hs_valid = 0, hs_ready = 0;
    logic [3:0] phase_req = '0;
    logic [3:0] phase;
    logic [ND-1:0] arb_grant;
    logic [IW-1:0] init_id, tgt_id;
    logic reconn, disc_pend, err_flag;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    busphase_seq #(.NUM_DEV(ND), .ID_W(IW), .CMD_BYTES(CB), .DATA_BYTES(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .sel_tgt(sel_tgt),
        .hs_valid(hs_valid), .hs_ready(hs_ready), .phase_req(phase_req),
        .phase(phase), .arb_grant(arb_grant), .init_id(init_id), .tgt_id(tgt_id),
        .reconn(reconn), .disc_pend(disc_pend), .err_flag(err_flag));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int top_bit(input logic [ND-1:0] v);
        int r = -1;
        for (int i = 0; i < ND; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Arbitrate from IDLE; checks ARB, grant, then the (re)selection result.
    task automatic arbitrate(input logic [ND-1:0] v, input logic [IW-1:0] t,
                             input logic [3:0] exp_sel);
        int w = top_bit(v);
        arb_req = v; sel_tgt = t;
        cyc();
        arb_req = '0;
        chk("R2 phase ARB", phase, ARB);
        chk("R2 grant", arb_grant, 1 << w);
        cyc();
        chk("R4 select phase", phase, exp_sel);
        chk("R10 err cleared", err_flag, 0);
    endtask

    // n handshakes with random stalls; request nxt on the final one.
    task automatic xfer(input int n, input logic [3:0] nxt, input logic [3:0] exp,
                        input string req);
        logic [3:0] cur;
        for (int i = 0; i < n; i++) begin
            cur = phase;
            if ($urandom % 3 == 0) begin
                hs_valid = 1; hs_ready = 0;
                cyc();
                chk("R5 stall holds", phase, cur);
            end
            hs_valid = 1; hs_ready = 1; phase_req = nxt;
            cyc();
            if (i < n - 1) chk("R5 mid-phase hold", phase, cur);
        end
        hs_valid = 0; hs_ready = 0;
        chk(req, phase, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) cyc();
        chk("R1 reset phase", phase, IDLE);
        chk("R1 reset grant", arb_grant, 0);
        chk("R1 reset err", err_flag, 0);
        chk("R1 reset disc_pend", disc_pend, 0);
        rst_n = 1;
        cyc();

        // Random contention with full commands (no suspended connection).
        for (int k = 0; k < 24; k++) begin
            logic [ND-1:0] v = ND'($urandom % 255 + 1);
            logic [IW-1:0] t = IW'($urandom);
            arbitrate(v, t, SEL);
            chk("R4 init_id", init_id, top_bit(v));
            chk("R4 tgt_id", tgt_id, t);
            chk("R4 reconn", reconn, 0);
            xfer(1, IDENT, IDENT, "R6 sel->ident");
            xfer(1, CMD, CMD, "R6 ident->cmd");
            if (k % 2 == 0) begin
                xfer(CB, DATA, DATA, "R7 cmd->data");
                xfer(DB, STATUS, STATUS, "R7 data->status");
            end else
                xfer(CB, STATUS, STATUS, "R7 cmd->status");
            xfer(1, DONE, DONE, "R9 status->done");
            xfer(1, IDLE, IDLE, "R9 done->idle");
            cyc();
            chk("R3 no queued loser", phase, IDLE);
        end

        // Requests while busy are ignored.
        arbitrate(8'h81, 3'd4, SEL);
        xfer(1, IDENT, IDENT, "R6 sel->ident");
        xfer(1, CMD, CMD, "R6 ident->cmd");
        arb_req = 8'hFF;
        cyc();
        chk("R3 busy phase holds", phase, CMD);
        chk("R3 busy grant zero", arb_grant, 0);
        arb_req = '0;

        // Disconnect, then reselect twice.
        xfer(CB, DISC, DISC, "R7 cmd->disc");
        xfer(1, IDLE, IDLE, "R8 disc->idle");
        chk("R8 disc_pend set", disc_pend, 1);
        arbitrate(8'h12, 3'd0, RESEL);   // ID4 target beats ID1
        chk("R4 reselect reconn", reconn, 1);
        chk("R4 reselect init", init_id, 7);
        chk("R4 reselect tgt", tgt_id, 4);
        xfer(1, IDENT, IDENT, "R6 resel->ident");
        xfer(1, RESTORE, RESTORE, "R6 ident->restore");
        xfer(1, DATA, DATA, "R7 restore->data");
        xfer(DB, SAVE, SAVE, "R7 data->save");
        xfer(1, DISC, DISC, "R7 save->disc");
        xfer(1, IDLE, IDLE, "R8 disc->idle again");
        chk("R8 still pending", disc_pend, 1);
        arbitrate(8'h10, 3'd0, RESEL);
        xfer(1, IDENT, IDENT, "R6 resel->ident");
        xfer(1, RESTORE, RESTORE, "R6 ident->restore");
        xfer(1, STATUS, STATUS, "R7 restore->status");
        xfer(1, DONE, DONE, "R9 status->done");
        xfer(1, IDLE, IDLE, "R9 done->idle");
        chk("R9 pending cleared", disc_pend, 0);

        // Illegal phase requests.
        arbitrate(8'h04, 3'd5, SEL);
        xfer(1, CMD, IDLE, "R10 sel->cmd illegal");
        chk("R10 err set", err_flag, 1);
        cyc();
        chk("R10 err sticky", err_flag, 1);
        arbitrate(8'h04, 3'd5, SEL);
        xfer(1, IDENT, IDENT, "R6 sel->ident");
        xfer(1, RESTORE, IDLE, "R10 new ident->restore illegal");
        chk("R10 err set again", err_flag, 1);
        arbitrate(8'h08, 3'd1, SEL);
        xfer(1, IDENT, IDENT, "R6 sel->ident");
        xfer(1, CMD, CMD, "R6 ident->cmd");
        xfer(CB, DATA, DATA, "R7 cmd->data");
        xfer(DB, DISC, IDLE, "R10 data->disc illegal");
        chk("R10 no pending on error", disc_pend, 0);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule